// File: doc/BRIEF.md
# Five-Stage In-Order Integer Core

This block is a compact 32-bit in-order processor core split into five pipeline stages: fetch, decode with operand read, ALU, memory access and register write-back. Each boundary between stages has its own holding registers, so up to five instructions are in flight at once and one instruction can retire in every clock. The core runs three classes of instruction. The first is register or immediate arithmetic and logic. The second is loads and stores, which take either a base register plus a displacement or the program counter plus an offset. The third is conditional branches to an address held in a register.

The core has no hazard detection and no forwarding. A result can be read by an instruction at least four slots later, so at least three other instructions must sit between the producer and the consumer. A branch is resolved in decode. The one instruction that follows it is always executed as a delay slot. Instruction and data memory are byte addressed, word aligned and must answer in the same cycle. Neither port has a valid/ready handshake and there is no back-pressure: the pipeline advances on every clock edge. A debug port reads any register at any time, combinationally.

Instruction word fields: opcode [31:27], ra [26:22], rb [21:17], rc [16:12], short constant k17 [16:0] (sign-extended), long constant k22 [21:0] (sign-extended), branch condition [2:0]. Opcodes: 0 no-op, 1 add, 2 subtract, 3 and, 4 or, 5 xor (ra = rb op rc), 6 add-immediate, 7 and-immediate, 8 or-immediate (ra = rb op k17), 9 load and 11 store with displacement (address rb + k17), 10 load and 12 store relative (address PC+4 + k22), 13 branch. Codes 14 to 31 act as no-ops.

Top module: `core_pipe5`

## Requirements
- R1: While reset is held and on the first cycle after it, the fetch address is 0, both data strobes are low, and every register reads 0 on the debug port.
- R2: Opcodes 1 to 5 write rb+rc, rb-rc, rb&rc, rb|rc and rb^rc into ra, wrapping modulo 2^32.
- R3: Opcodes 6 to 8 combine rb with k17 sign-extended to 32 bits (add, and, or) and write the result into ra.
- R4: A displacement load or store uses the address R[rb]+k17. An rb field of 0 gives base 0 even when register 0 holds a nonzero value. Register 0 is otherwise an ordinary register.
- R5: A relative load or store uses the address (own address + 4) + k22, with k22 sign-extended.
- R6: A store drives dmem_wr high for one cycle, with R[ra] on dmem_wdata and the effective address on dmem_addr, and writes no register.
- R7: Arithmetic instructions raise no data strobe. Each load raises dmem_rd for exactly one cycle, and the read word lands in ra.
- R8: A branch (opcode 13) tests R[rc] under condition 0 never, 1 always, 2 zero, 3 nonzero, 4 non-negative, 5 negative; 6 and 7 never. If the test passes, fetch continues at R[rb]; otherwise the address advances by 4.
- R9: The instruction after a branch always completes, whether or not the branch is taken.
- R10: A register written by an instruction is read correctly by any instruction four or more slots later, and the debug port returns the register selected by dbg_sel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 32 | Fetch byte address |
| imem_data | input | 32 | Instruction word at imem_addr, same cycle |
| dmem_rd | output | 1 | Data read strobe |
| dmem_wr | output | 1 | Data write strobe |
| dmem_addr | output | 32 | Data byte address |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at dmem_addr, same cycle |
| dbg_sel | input | 5 | Debug register select |
| dbg_val | output | 32 | Debug register value |

## Verification
The bench builds the core with the default word width of 32. This makes bit 31 the sign bit, so the negative and non-negative branch tests, the sign extension of both constants and the address wrap below zero can all be hit with hand-picked words. A 64-word instruction and data model is enough for the short, spaced programs. Each program runs only until its last write-back, so the fetch address never reaches the point where the model wraps.

// File: rtl/core_pkg.sv
package core_pkg;
  localparam int ILEN = 32;
  localparam int NREG = 32;
  localparam int RIDX = $clog2(NREG);

  typedef enum logic [4:0] {
    OP_NOP = 5'd0, OP_ADD = 5'd1, OP_SUB = 5'd2, OP_AND = 5'd3, OP_OR = 5'd4,
    OP_XOR = 5'd5, OP_ADDI = 5'd6, OP_ANDI = 5'd7, OP_ORI = 5'd8,
    OP_LD = 5'd9, OP_LDR = 5'd10, OP_ST = 5'd11, OP_STR = 5'd12, OP_BR = 5'd13
  } op_e;

  typedef enum logic [2:0] {
    CC_NEVER = 3'd0, CC_ALWAYS = 3'd1, CC_ZERO = 3'd2,
    CC_NZ = 3'd3, CC_GE = 3'd4, CC_LT = 3'd5
  } cc_e;

  function automatic logic is_load(logic [4:0] op);
    return (op == OP_LD) || (op == OP_LDR);
  endfunction

  function automatic logic is_store(logic [4:0] op);
    return (op == OP_ST) || (op == OP_STR);
  endfunction

  function automatic logic writes_reg(logic [4:0] op);
    return ((op >= OP_ADD) && (op <= OP_ORI)) || is_load(op);
  endfunction
endpackage

// File: rtl/core_regfile.sv
module core_regfile
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [RIDX-1:0] waddr,
  input  logic [XLEN-1:0] wdata,
  input  logic [RIDX-1:0] ra_b,
  input  logic [RIDX-1:0] ra_c,
  input  logic [RIDX-1:0] ra_a,
  input  logic [RIDX-1:0] ra_dbg,
  output logic [XLEN-1:0] rd_b,
  output logic [XLEN-1:0] rd_c,
  output logic [XLEN-1:0] rd_a,
  output logic [XLEN-1:0] rd_dbg
);
  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  assign rd_b   = regs[ra_b];
  assign rd_c   = regs[ra_c];
  assign rd_a   = regs[ra_a];
  assign rd_dbg = regs[ra_dbg];

  // R10: a write lands and is visible on the next cycle
  assert_write_visible_R10: assert property (@(posedge clk) disable iff (rst)
    we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [4:0]      op,
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  output logic [XLEN-1:0] y
);
  always_comb begin
    case (op)
      OP_ADD, OP_ADDI, OP_LD, OP_LDR, OP_ST, OP_STR: y = a + b;
      OP_SUB:           y = a - b;
      OP_AND, OP_ANDI:  y = a & b;
      OP_OR, OP_ORI:    y = a | b;
      OP_XOR:           y = a ^ b;
      default:          y = '0;
    endcase
  end
endmodule

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] pc_next,
  input  logic [XLEN-1:0] val_b,
  input  logic [XLEN-1:0] val_c,
  input  logic [XLEN-1:0] val_a,
  output logic [4:0]      op,
  output logic [RIDX-1:0] idx_a,
  output logic [RIDX-1:0] idx_b,
  output logic [RIDX-1:0] idx_c,
  output logic [XLEN-1:0] opnd_x,
  output logic [XLEN-1:0] opnd_y,
  output logic [XLEN-1:0] st_val,
  output logic            take,
  output logic [XLEN-1:0] target
);
  localparam int K17 = 17;
  localparam int K22 = 22;

  logic [XLEN-1:0] k17s, k22s;
  logic [2:0]      cc;
  logic            cc_pass;

  assign op    = instr[31:27];
  assign idx_a = instr[26:22];
  assign idx_b = instr[21:17];
  assign idx_c = instr[16:12];
  assign cc    = instr[2:0];
  assign k17s  = {{(XLEN-K17){instr[K17-1]}}, instr[K17-1:0]};
  assign k22s  = {{(XLEN-K22){instr[K22-1]}}, instr[K22-1:0]};

  always_comb begin
    opnd_x = val_b;
    opnd_y = '0;
    case (op)
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_XOR: opnd_y = val_c;
      OP_ADDI, OP_ANDI, OP_ORI:              opnd_y = k17s;
      OP_LD, OP_ST: begin
        opnd_x = (idx_b == '0) ? '0 : val_b;
        opnd_y = k17s;
      end
      OP_LDR, OP_STR: begin
        opnd_x = pc_next;
        opnd_y = k22s;
      end
      default: opnd_y = '0;
    endcase
  end

  always_comb begin
    case (cc)
      CC_ALWAYS: cc_pass = 1'b1;
      CC_ZERO:   cc_pass = (val_c == '0);
      CC_NZ:     cc_pass = (val_c != '0);
      CC_GE:     cc_pass = !val_c[XLEN-1];
      CC_LT:     cc_pass = val_c[XLEN-1];
      default:   cc_pass = 1'b0;
    endcase
  end

  assign take   = (op == OP_BR) && cc_pass;
  assign target = val_b;
  assign st_val = val_a;

  // R8: a redirect never comes from a never-code
  always_comb begin
    if (take) begin
      assert_taken_code_R8: assert (instr[2:0] != 3'd0 && instr[2:0] < 3'd6);
    end
  end
endmodule

// File: rtl/core_pipe5.sv
module core_pipe5
  import core_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  output logic [XLEN-1:0] imem_addr,
  input  logic [ILEN-1:0] imem_data,
  output logic            dmem_rd,
  output logic            dmem_wr,
  output logic [XLEN-1:0] dmem_addr,
  output logic [XLEN-1:0] dmem_wdata,
  input  logic [XLEN-1:0] dmem_rdata,
  input  logic [RIDX-1:0] dbg_sel,
  output logic [XLEN-1:0] dbg_val
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  // fetch -> decode
  logic [XLEN-1:0] pc, fe_pcn;
  logic [ILEN-1:0] fe_instr;
  // decode -> alu
  logic [XLEN-1:0] dc_x, dc_y, dc_st;
  logic [4:0]      dc_op;
  logic [RIDX-1:0] dc_ra;
  // alu -> memory
  logic [XLEN-1:0] ex_res, ex_st;
  logic [4:0]      ex_op;
  logic [RIDX-1:0] ex_ra;
  // memory -> write
  logic [XLEN-1:0] mm_res;
  logic [4:0]      mm_op;
  logic [RIDX-1:0] mm_ra;

  logic [4:0]      d_op;
  logic [RIDX-1:0] d_ia, d_ib, d_ic;
  logic [XLEN-1:0] d_x, d_y, d_st, d_tgt, v_a, v_b, v_c, alu_y;
  logic            d_take, rf_we;

  core_decode #(.XLEN(XLEN)) u_dec (
    .instr(fe_instr), .pc_next(fe_pcn), .val_b(v_b), .val_c(v_c), .val_a(v_a),
    .op(d_op), .idx_a(d_ia), .idx_b(d_ib), .idx_c(d_ic),
    .opnd_x(d_x), .opnd_y(d_y), .st_val(d_st), .take(d_take), .target(d_tgt)
  );

  core_alu #(.XLEN(XLEN)) u_alu (.op(dc_op), .a(dc_x), .b(dc_y), .y(alu_y));

  assign rf_we = writes_reg(mm_op);

  core_regfile #(.XLEN(XLEN)) u_rf (
    .clk(clk), .rst(rst), .we(rf_we), .waddr(mm_ra), .wdata(mm_res),
    .ra_b(d_ib), .ra_c(d_ic), .ra_a(d_ia), .ra_dbg(dbg_sel),
    .rd_b(v_b), .rd_c(v_c), .rd_a(v_a), .rd_dbg(dbg_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0; fe_pcn <= '0; fe_instr <= '0;
      dc_x <= '0; dc_y <= '0; dc_st <= '0; dc_op <= OP_NOP; dc_ra <= '0;
      ex_res <= '0; ex_st <= '0; ex_op <= OP_NOP; ex_ra <= '0;
      mm_res <= '0; mm_op <= OP_NOP; mm_ra <= '0;
    end else begin
      pc       <= d_take ? d_tgt : pc + STEP;
      fe_instr <= imem_data;
      fe_pcn   <= pc + STEP;
      dc_x     <= d_x;
      dc_y     <= d_y;
      dc_st    <= d_st;
      dc_op    <= d_op;
      dc_ra    <= d_ia;
      ex_res   <= alu_y;
      ex_st    <= dc_st;
      ex_op    <= dc_op;
      ex_ra    <= dc_ra;
      mm_res   <= is_load(ex_op) ? dmem_rdata : ex_res;
      mm_op    <= ex_op;
      mm_ra    <= ex_ra;
    end
  end

  assign imem_addr  = pc;
  assign dmem_rd    = is_load(ex_op);
  assign dmem_wr    = is_store(ex_op);
  assign dmem_addr  = ex_res;
  assign dmem_wdata = ex_st;

  // R1: fetch starts at address zero after reset
  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> imem_addr == '0);
  // R8: without a redirect the fetch address steps by one word
  assert_pc_step_R8: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(d_take)) |-> imem_addr == $past(imem_addr) + STEP);
  // R6: a store reaching write-back writes no register
  assert_store_no_write_R6: assert property (@(posedge clk) disable iff (rst)
    dmem_wr |=> !rf_we);
endmodule

// File: tb/tb_core_pipe5.sv
`timescale 1ns/1ps
module tb_core_pipe5;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata, dbg_val;
  logic        dmem_rd, dmem_wr;
  logic [4:0]  dbg_sel = '0;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [31:0] st_a [4];
  logic [31:0] st_d [4];
  int st_cnt, rd_cnt;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  core_pipe5 dut (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr), .dmem_addr(dmem_addr),
    .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  // store log and strobe counts, sampled mid-cycle
  always @(negedge clk) begin
    if (rst) begin
      st_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (dmem_wr) begin
        if (st_cnt < 4) begin
          st_a[st_cnt] <= dmem_addr;
          st_d[st_cnt] <= dmem_wdata;
        end
        st_cnt <= st_cnt + 1;
      end
      if (dmem_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  typedef struct packed {
    logic [4:0]  op;
    logic [16:0] imm;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{5'd1, 17'd0,       32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000},
    '{5'd2, 17'd0,       32'h0000_0005, 32'h0000_0009, 32'hFFFF_FFFC},
    '{5'd3, 17'd0,       32'hF0F0_00FF, 32'h0FF0_0F0F, 32'h00F0_000F},
    '{5'd4, 17'd0,       32'h1200_0034, 32'h0045_6700, 32'h1245_6734},
    '{5'd5, 17'd0,       32'hFFFF_0000, 32'h0F0F_0F0F, 32'hF0F0_0F0F},
    '{5'd6, 17'h1FFFF,   32'h0000_0100, 32'h0,         32'h0000_00FF},
    '{5'd7, 17'h10000,   32'hABCD_1234, 32'h0,         32'hABCD_0000},
    '{5'd8, 17'h0FFFF,   32'h0000_0000, 32'h0,         32'h0000_FFFF}
  };

  function automatic logic [31:0] e_r(int op, int ra, int rb, int rc);
    return {5'(op), 5'(ra), 5'(rb), 5'(rc), 12'd0};
  endfunction
  function automatic logic [31:0] e_i(int op, int ra, int rb, int k);
    return {5'(op), 5'(ra), 5'(rb), 17'(k)};
  endfunction
  function automatic logic [31:0] e_rel(int op, int ra, int k);
    return {5'(op), 5'(ra), 22'(k)};
  endfunction
  function automatic logic [31:0] e_br(int rb, int rc, int cc);
    return {5'd13, 5'd0, 5'(rb), 5'(rc), 9'd0, 3'(cc)};
  endfunction
  function automatic logic br_expect(int cc, logic [31:0] v);
    case (cc)
      1: return 1'b1;
      2: return v == 0;
      3: return v != 0;
      4: return !v[31];
      5: return v[31];
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic reg_val(input int idx, output logic [31:0] v);
    dbg_sel = 5'(idx);
    #1 v = dbg_val;
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
    end
  endtask

  task automatic run(input int n);
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd1, 32'd0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, w;
    // R1: reset state
    clear_mem();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "fetch addr in reset", imem_addr, 32'd0);
    check("R1", "strobes in reset", {30'd0, dmem_rd, dmem_wr}, 32'd0);
    reg_val(7, v);
    check("R1", "reg7 in reset", v, 32'd0);

    // R2 R3 R7 R10: vector table, operands loaded from data memory
    for (int k = 0; k < NV; k++) begin
      clear_mem();
      dmem[0] = VEC[k].a;
      dmem[1] = VEC[k].b;
      imem[0] = e_i(9, 1, 0, 0);
      imem[1] = e_i(9, 2, 0, 4);
      imem[5] = (VEC[k].op >= 5'd6) ? e_i(int'(VEC[k].op), 3, 1, int'(VEC[k].imm))
                                    : e_r(int'(VEC[k].op), 3, 1, 2);
      run(16);
      reg_val(3, v);
      check((VEC[k].op >= 5'd6) ? "R3" : "R2", $sformatf("vector %0d result", k),
            v, VEC[k].exp);
      check("R7", $sformatf("vector %0d read strobes", k), rd_cnt, 32'd2);
      check("R7", $sformatf("vector %0d write strobes", k), st_cnt, 32'd0);
    end

    // R1: registers cleared by a later reset
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    reg_val(3, v);
    check("R1", "reg3 cleared by reset", v, 32'd0);

    // R5: relative loads, forward and backward
    clear_mem();
    dmem[4] = 32'h1111_2222;
    dmem[0] = 32'h3333_4444;
    imem[1] = e_rel(10, 1, 8);
    imem[2] = e_rel(10, 2, -12);
    run(12);
    reg_val(1, v);
    check("R5", "relative load forward", v, 32'h1111_2222);
    reg_val(2, v);
    check("R5", "relative load backward", v, 32'h3333_4444);

    // R4: displacement loads, zero base when rb is 0
    clear_mem();
    dmem[0]  = 32'h0000_0040;
    dmem[2]  = 32'hAAAA_0002;
    dmem[18] = 32'hBBBB_0012;
    imem[0] = e_i(9, 0, 0, 0);
    imem[1] = e_i(9, 1, 0, 0);
    imem[5] = e_i(9, 5, 0, 8);
    imem[6] = e_i(9, 7, 1, 8);
    imem[7] = e_i(9, 8, 1, -56);
    run(16);
    reg_val(0, v);
    check("R4", "register 0 is writable", v, 32'h0000_0040);
    reg_val(5, v);
    check("R4", "rb field 0 gives base 0", v, 32'hAAAA_0002);
    reg_val(7, v);
    check("R4", "positive displacement", v, 32'hBBBB_0012);
    reg_val(8, v);
    check("R4", "negative displacement", v, 32'hAAAA_0002);

    // R6 R5: stores in both modes
    clear_mem();
    dmem[0] = 32'hCAFE_F00D;
    dmem[1] = 32'h0000_0020;
    imem[0] = e_i(9, 1, 0, 0);
    imem[1] = e_i(9, 2, 0, 4);
    imem[5] = e_i(11, 1, 2, 4);
    imem[6] = e_rel(12, 1, 100);
    imem[7] = e_i(11, 1, 2, -36);
    run(16);
    check("R6", "store count", st_cnt, 32'd3);
    check("R6", "store 0 address", st_a[0], 32'h0000_0024);
    check("R6", "store 0 data", st_d[0], 32'hCAFE_F00D);
    check("R5", "relative store address", st_a[1], 32'h0000_0080);
    check("R6", "store below zero address", st_a[2], 32'hFFFF_FFFC);
    reg_val(1, v);
    check("R6", "source register unchanged", v, 32'hCAFE_F00D);
    reg_val(2, v);
    check("R6", "base register unchanged", v, 32'h0000_0020);

    // R8 R9: every condition code against three test values
    for (int cc = 0; cc < 8; cc++) begin
      for (int t = 0; t < 3; t++) begin
        w = (t == 0) ? 32'd0 : (t == 1) ? 32'd5 : 32'h8000_0000;
        clear_mem();
        dmem[0] = 32'h0000_0040;
        dmem[1] = w;
        imem[0]  = e_i(9, 1, 0, 0);
        imem[1]  = e_i(9, 2, 0, 4);
        imem[5]  = e_br(1, 2, cc);
        imem[6]  = e_i(6, 3, 0, 1);
        imem[7]  = e_i(6, 4, 0, 1);
        imem[16] = e_i(6, 5, 0, 1);
        run(16);
        reg_val(3, v);
        check("R9", $sformatf("delay slot cc=%0d v=%h", cc, w), v, 32'd1);
        reg_val(4, v);
        check("R8", $sformatf("fall-through cc=%0d v=%h", cc, w), v,
              br_expect(cc, w) ? 32'd0 : 32'd1);
        reg_val(5, v);
        check("R8", $sformatf("target reached cc=%0d v=%h", cc, w), v,
              br_expect(cc, w) ? 32'd1 : 32'd0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule